// File: doc/BRIEF.md
# Serial Port Modem Control and Loopback Router

This block holds the per-channel modem control byte of a 16550-style serial port and uses it to route the signals around the channel. The control byte picks a loopback bit and four modem bits. An external mode input picks internal connection mode. Together they select one of three routings: standard, internal connection or diagnostic loopback. In each routing the block steers the serial data path between the pins and the shift registers. It also drives the active-low request-to-send and terminal-ready pins. It produces the four active-high modem status inputs (clear-to-send, data-set-ready, ring, carrier detect) that the status register samples.

Software writes the byte through a one-register write port and can read it back at any time. A write takes effect at the clock edge that captures it. After that edge, all routing outputs are decoded combinationally from the stored byte, the mode input and the pins. One control bit, together with an external configuration input, also chooses whether the channel interrupt comes from the serial core or from an external interrupt line.

Top module: `uart_mdm_ctl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the control byte is cleared, and `rd_data` reads 0x00 after that edge.
- R2: A write (`wr_en` high at a rising edge) stores `wr_data` with bits 7..5 forced to zero. The new value shows on `rd_data` after that edge and not before. With `wr_en` low the byte holds.
- R3: With the loop bit (bit 4) set, `tx_pin_o` is 1 and `rx_shift_o` equals `tx_shift_i`.
- R4: With the loop bit set, `rts_n_o` and `dtr_n_o` are 1. The four modem input pins have no effect on any output.
- R5: With the loop bit set, `ri_o` equals bit 2, `dcd_o` equals bit 3, `cts_o` equals bit 1 and `dsr_o` equals bit 0.
- R6: With the loop bit clear and `int_conn_i` high, `cts_o` equals bit 1, and both `dsr_o` and `dcd_o` equal bit 0. `rts_n_o` is the inverse of bit 1 and `dtr_n_o` is the inverse of bit 0. `ri_o` is the inverse of `ri_n_i`.
- R7: With the loop bit clear and `int_conn_i` low, `rts_n_o` is the inverse of bit 1 and `dtr_n_o` is the inverse of bit 0. Each status output is the inverse of its active-low pin. Bit 2 has no effect on any output.
- R8: With the loop bit clear, `tx_pin_o` equals `tx_shift_i` and `rx_shift_o` equals `rx_pin_i`.
- R9: `irq_sel_o` is 1 exactly when bit 3 and `irq_cfg_i` are both 1. `irq_o` then equals `sio_irq_i`; otherwise it equals `ext_irq_i`. This holds in every routing.
- R10: When the loop bit is set, loopback routing applies whatever the value of `int_conn_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Stored control byte |
| int_conn_i | input | 1 | Selects internal connection mode |
| tx_shift_i | input | 1 | Transmit shift register output |
| rx_pin_i | input | 1 | Receive data pin |
| tx_pin_o | output | 1 | Transmit data pin |
| rx_shift_o | output | 1 | Receive shift register input |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring pin, active low |
| dcd_n_i | input | 1 | Carrier detect pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| dtr_n_o | output | 1 | Terminal-ready pin, active low |
| cts_o | output | 1 | Internal clear-to-send status |
| dsr_o | output | 1 | Internal data-set-ready status |
| ri_o | output | 1 | Internal ring status |
| dcd_o | output | 1 | Internal carrier detect status |
| irq_cfg_i | input | 1 | Interrupt configuration input |
| sio_irq_i | input | 1 | Serial core interrupt |
| ext_irq_i | input | 1 | External interrupt line |
| irq_sel_o | output | 1 | 1 when the serial core interrupt is selected |
| irq_o | output | 1 | Selected channel interrupt |

## Verification
The routing assertions sample the combinational outputs at the rising edge. They therefore assume that every input is synchronous to `clk`, free of X and settled before that edge. The bench meets this by changing the mode input, pins, data bits, interrupt lines and write port only at the falling edge. It mixes random control bytes, including reserved bits set, with random pin levels and random mode input values, so all three routings are reached with both pin polarities. Directed cases cover reset, an all-ones write, and loopback together with the internal connection request.

// File: rtl/mdm_ctl_pkg.sv
package mdm_ctl_pkg;
  localparam int CTRL_W   = 8;
  localparam int B_DTR    = 0;
  localparam int B_RTS    = 1;
  localparam int B_OUT1   = 2;
  localparam int B_OUT2   = 3;
  localparam int B_LOOP   = 4;
  localparam logic [CTRL_W-1:0] CTRL_MASK  = 8'h1F;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h00;

  typedef enum logic [1:0] {
    RT_STD  = 2'd0,
    RT_ICON = 2'd1,
    RT_DIAG = 2'd2
  } route_mode_e;

  // status vector order: [3]=cts [2]=dsr [1]=ri [0]=dcd
  localparam int NSTAT = 4;
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL & MASK;
    else if (wr_en) q <= wr_data & MASK;
  end
endmodule

// File: rtl/mdm_ctl_mode_dec.sv
module mdm_ctl_mode_dec
  import mdm_ctl_pkg::*;
(
  input  logic        loop_bit,
  input  logic        int_conn,
  output route_mode_e mode
);
  // loopback wins over the internal connection request
  always_comb begin
    if (loop_bit)      mode = RT_DIAG;
    else if (int_conn) mode = RT_ICON;
    else               mode = RT_STD;
  end
endmodule

// File: rtl/mdm_ctl_route.sv
module mdm_ctl_route
  import mdm_ctl_pkg::*;
#(
  parameter int NS = NSTAT
) (
  input  route_mode_e   mode,
  input  logic          dtr_bit,
  input  logic          rts_bit,
  input  logic          out1_bit,
  input  logic          out2_bit,
  input  logic          tx_shift,
  input  logic          rx_pin,
  input  logic [NS-1:0] pin_n,
  output logic          tx_pin,
  output logic          rx_shift,
  output logic          rts_n,
  output logic          dtr_n,
  output logic [NS-1:0] stat
);
  logic [NS-1:0] pin_act;

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_inv
      assign pin_act[gi] = ~pin_n[gi];
    end
  endgenerate

  always_comb begin
    tx_pin   = tx_shift;
    rx_shift = rx_pin;
    rts_n    = ~rts_bit;
    dtr_n    = ~dtr_bit;
    stat     = pin_act;
    unique case (mode)
      RT_DIAG: begin
        tx_pin   = 1'b1;
        rx_shift = tx_shift;
        rts_n    = 1'b1;
        dtr_n    = 1'b1;
        stat     = {rts_bit, dtr_bit, out1_bit, out2_bit};
      end
      RT_ICON: begin
        stat     = {rts_bit, dtr_bit, pin_act[1], dtr_bit};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mdm_ctl_irqsel.sv
module mdm_ctl_irqsel (
  input  logic out2_bit,
  input  logic cfg,
  input  logic sio_irq,
  input  logic ext_irq,
  output logic sel_int,
  output logic irq
);
  assign sel_int = out2_bit & cfg;
  assign irq     = sel_int ? sio_irq : ext_irq;
endmodule

// File: rtl/uart_mdm_ctl.sv
module uart_mdm_ctl
  import mdm_ctl_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RST_VAL = CTRL_RESET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              int_conn_i,
  input  logic              tx_shift_i,
  input  logic              rx_pin_i,
  output logic              tx_pin_o,
  output logic              rx_shift_o,
  input  logic              cts_n_i,
  input  logic              dsr_n_i,
  input  logic              ri_n_i,
  input  logic              dcd_n_i,
  output logic              rts_n_o,
  output logic              dtr_n_o,
  output logic              cts_o,
  output logic              dsr_o,
  output logic              ri_o,
  output logic              dcd_o,
  input  logic              irq_cfg_i,
  input  logic              sio_irq_i,
  input  logic              ext_irq_i,
  output logic              irq_sel_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  route_mode_e       mode;
  logic [NSTAT-1:0]  stat;

  mdm_ctl_reg #(.W(CTRL_W), .MASK(CTRL_MASK), .RST_VAL(RST_VAL)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .q(ctrl_q)
  );

  mdm_ctl_mode_dec u_mode (
    .loop_bit(ctrl_q[B_LOOP]), .int_conn(int_conn_i), .mode(mode)
  );

  mdm_ctl_route #(.NS(NSTAT)) u_route (
    .mode(mode),
    .dtr_bit(ctrl_q[B_DTR]), .rts_bit(ctrl_q[B_RTS]),
    .out1_bit(ctrl_q[B_OUT1]), .out2_bit(ctrl_q[B_OUT2]),
    .tx_shift(tx_shift_i), .rx_pin(rx_pin_i),
    .pin_n({cts_n_i, dsr_n_i, ri_n_i, dcd_n_i}),
    .tx_pin(tx_pin_o), .rx_shift(rx_shift_o),
    .rts_n(rts_n_o), .dtr_n(dtr_n_o), .stat(stat)
  );

  mdm_ctl_irqsel u_irq (
    .out2_bit(ctrl_q[B_OUT2]), .cfg(irq_cfg_i),
    .sio_irq(sio_irq_i), .ext_irq(ext_irq_i),
    .sel_int(irq_sel_o), .irq(irq_o)
  );

  assign rd_data = ctrl_q;
  assign {cts_o, dsr_o, ri_o, dcd_o} = stat;
endmodule

// File: rtl/uart_mdm_ctl_chk.sv
module uart_mdm_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       int_conn_i,
  input logic       tx_shift_i,
  input logic       rx_pin_i,
  input logic       tx_pin_o,
  input logic       rx_shift_o,
  input logic       cts_n_i,
  input logic       dsr_n_i,
  input logic       ri_n_i,
  input logic       dcd_n_i,
  input logic       rts_n_o,
  input logic       dtr_n_o,
  input logic       cts_o,
  input logic       dsr_o,
  input logic       ri_o,
  input logic       dcd_o,
  input logic       irq_cfg_i,
  input logic       sio_irq_i,
  input logic       ext_irq_i,
  input logic       irq_sel_o,
  input logic       irq_o
);
  logic lp;
  assign lp = rd_data[4];

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> rd_data == 8'h00);

  a_r2_write_store: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & 8'h1F));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));

  a_r3_loop_data: assert property (@(posedge clk) disable iff (rst)
    lp |-> (tx_pin_o && rx_shift_o == tx_shift_i));

  a_r4_loop_pins_idle: assert property (@(posedge clk) disable iff (rst)
    lp |-> (rts_n_o && dtr_n_o));

  a_r5_loop_status: assert property (@(posedge clk) disable iff (rst)
    lp |-> ({ri_o, dcd_o, cts_o, dsr_o} == {rd_data[2], rd_data[3], rd_data[1], rd_data[0]}));

  a_r6_icon: assert property (@(posedge clk) disable iff (rst)
    (!lp && int_conn_i) |-> (cts_o == rd_data[1] && dsr_o == rd_data[0] &&
      dcd_o == rd_data[0] && rts_n_o != rd_data[1] && dtr_n_o != rd_data[0] && ri_o != ri_n_i));

  a_r7_std: assert property (@(posedge clk) disable iff (rst)
    (!lp && !int_conn_i) |-> (rts_n_o != rd_data[1] && dtr_n_o != rd_data[0] &&
      cts_o != cts_n_i && dsr_o != dsr_n_i && ri_o != ri_n_i && dcd_o != dcd_n_i));

  a_r8_pass_data: assert property (@(posedge clk) disable iff (rst)
    !lp |-> (tx_pin_o == tx_shift_i && rx_shift_o == rx_pin_i));

  a_r9_irq_sel: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((rd_data[3] && irq_cfg_i) ? sio_irq_i : ext_irq_i));
endmodule

bind uart_mdm_ctl uart_mdm_ctl_chk chk_i (.*);

// File: tb/uart_mdm_ctl_tb_top.sv
module uart_mdm_ctl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic int_conn_i = 1'b0, tx_shift_i = 1'b1, rx_pin_i = 1'b1;
  logic tx_pin_o, rx_shift_o;
  logic cts_n_i = 1'b1, dsr_n_i = 1'b1, ri_n_i = 1'b1, dcd_n_i = 1'b1;
  logic rts_n_o, dtr_n_o, cts_o, dsr_o, ri_o, dcd_o;
  logic irq_cfg_i = 1'b0, sio_irq_i = 1'b0, ext_irq_i = 1'b0;
  logic irq_sel_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model_q = 8'h00;

  always #4 clk = ~clk;

  uart_mdm_ctl dut_i (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {tx_pin, rx_shift, rts_n, dtr_n, cts, dsr, ri, dcd}
  function automatic logic [7:0] exp_route(input logic [7:0] q, input logic ic,
      input logic txs, input logic rxp, input logic [3:0] pn);
    logic [3:0] act;
    act = ~pn;
    if (q[4])   return {1'b1, txs, 1'b1, 1'b1, q[1], q[0], q[2], q[3]};
    else if (ic) return {txs, rxp, ~q[1], ~q[0], q[1], q[0], act[1], q[0]};
    else        return {txs, rxp, ~q[1], ~q[0], act};
  endfunction

  function automatic logic [1:0] exp_irq(input logic [7:0] q, input logic cfg,
      input logic si, input logic ei);
    logic s;
    s = q[3] & cfg;
    return {s, s ? si : ei};
  endfunction

  task automatic check_all();
    logic [7:0] act, exp;
    logic [1:0] ia, ie;
    act = {tx_pin_o, rx_shift_o, rts_n_o, dtr_n_o, cts_o, dsr_o, ri_o, dcd_o};
    exp = exp_route(model_q, int_conn_i, tx_shift_i, rx_pin_i, {cts_n_i, dsr_n_i, ri_n_i, dcd_n_i});
    check("R2 readback", {8'h0, rd_data}, {8'h0, model_q});
    if (model_q[4]) begin
      check("R3 loop data", {14'h0, act[7:6]}, {14'h0, exp[7:6]});
      check("R4 loop pins", {14'h0, act[5:4]}, {14'h0, exp[5:4]});
      check(int_conn_i ? "R10 loop priority" : "R5 loop status", {12'h0, act[3:0]}, {12'h0, exp[3:0]});
    end else if (int_conn_i) begin
      check("R8 data pass", {14'h0, act[7:6]}, {14'h0, exp[7:6]});
      check("R6 internal connection", {10'h0, act[5:0]}, {10'h0, exp[5:0]});
    end else begin
      check("R8 data pass", {14'h0, act[7:6]}, {14'h0, exp[7:6]});
      check("R7 standard", {10'h0, act[5:0]}, {10'h0, exp[5:0]});
    end
    ia = {irq_sel_o, irq_o};
    ie = exp_irq(model_q, irq_cfg_i, sio_irq_i, ext_irq_i);
    check("R9 irq select", {14'h0, ia}, {14'h0, ie});
  endtask

  // drive at negedge, cycle a posedge, check shortly after
  task automatic step(input logic we, input logic [7:0] wd, input logic ic,
      input logic [3:0] pn, input logic txs, input logic rxp, input logic [2:0] irq_in);
    @(negedge clk);
    wr_en = we; wr_data = wd; int_conn_i = ic;
    {cts_n_i, dsr_n_i, ri_n_i, dcd_n_i} = pn;
    tx_shift_i = txs; rx_pin_i = rxp;
    {irq_cfg_i, sio_irq_i, ext_irq_i} = irq_in;
    #1;
    if (we) check("R2 no early update", {8'h0, rd_data}, {8'h0, model_q});
    @(posedge clk);
    if (we) model_q = wd & 8'h1F;
    #2;
    check_all();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset value", {8'h0, rd_data}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    // directed corner cases
    step(1'b1, 8'hFF, 1'b0, 4'hF, 1'b0, 1'b1, 3'b110);       // R2 masks reserved, loop on
    step(1'b0, 8'h00, 1'b1, 4'h0, 1'b1, 1'b0, 3'b101);       // R10 loop with int_conn
    step(1'b1, 8'h04, 1'b0, 4'h5, 1'b1, 1'b0, 3'b101);       // R7 out1 only, no effect
    step(1'b1, 8'h03, 1'b1, 4'hD, 1'b0, 1'b1, 3'b110);       // R6
    step(1'b1, 8'h08, 1'b0, 4'hA, 1'b1, 1'b1, 3'b110);       // R9 internal irq chosen

    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 2) == 0, 8'($urandom), 1'($urandom), 4'($urandom),
           1'($urandom), 1'($urandom), 3'($urandom));
    end

    // R1 reset from non-zero value
    step(1'b1, 8'h1B, 1'b0, 4'h0, 1'b0, 1'b0, 3'b000);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); model_q = 8'h00; #2;
    check("R1 reset clears", {8'h0, rd_data}, 16'h0000);
    @(negedge clk); rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule